// File: doc/BRIEF.md
# Sign-Magnitude Adder-Subtractor

This block adds or subtracts two numbers in sign-magnitude form. Each operand carries a sign bit above a parameterised magnitude field (four bits by default). One shared ripple-carry adder serves every case. Before the adder, an XOR stage can invert the B magnitude, and the same control bit feeds the adder's carry-in, so the adder produces either A+B or A+~B+1.

The block compares the two signs with the requested operation. From that it decides whether the magnitudes are added or subtracted. After a magnitude subtraction, the adder's end carry shows whether the difference came out negative. If it did, the magnitude is replaced by its two's complement and the sign is flipped.

A caller presents both operands and the operation and pulses `start` for one cycle. One clock later the registered result appears with `res_valid` high for one cycle. The result stays on the outputs until the next start.

Top module: `smag_addsub`

## Requirements
- R1: An operand's top bit (bit MAG_W) is its sign, with 1 meaning negative. Its low MAG_W bits are the magnitude. `op_sub`=1 requests A−B and `op_sub`=0 requests A+B.
- R2: The magnitudes are added when sign(A) equals sign(B) XOR `op_sub`. Otherwise they are subtracted.
- R3: When the magnitudes are added, the result magnitude is (|A|+|B|) mod 2^MAG_W. The result sign is sign(A). Both `res_carry` and `res_ovf` equal the adder's carry-out.
- R4: When the magnitudes are subtracted, the adder forms |A|+~|B|+1 and `res_ovf` is 0.
- R5: When the magnitudes are subtracted and the end carry is 1, `res_carry`=1 and the magnitude is |A|−|B|. The sign is sign(A), except that a zero magnitude is given a positive sign.
- R6: When the magnitudes are subtracted and the end carry is 0, `res_carry`=0, the magnitude is |B|−|A| (the two's complement of the raw sum) and the sign is the inverse of sign(A).
- R7: A `start` pulse is captured on a rising clock edge. `res_valid` is high in exactly the cycle that follows a cycle with `start` high.
- R8: In a cycle without `start`, changes on `opa`, `opb` and `op_sub` leave `res_sign`, `res_mag`, `res_ovf` and `res_carry` unchanged.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Capture strobe for the operands and operation |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| opa | input | MAG_W+1 | Operand A, sign bit above magnitude |
| opb | input | MAG_W+1 | Operand B, sign bit above magnitude |
| res_valid | output | 1 | High for one cycle after a start |
| res_sign | output | 1 | Result sign, 1 = negative |
| res_mag | output | MAG_W | Result magnitude |
| res_ovf | output | 1 | Magnitude overflow flag |
| res_carry | output | 1 | End carry of the magnitude adder |

## Verification
Some rules are checked on every cycle from the block's internal path, carry and correction wires. These are: a subtract path never raises overflow; an add path's overflow equals its carry; a negative difference flips the sign; and a zero difference is positive. The cycle rules are also checked every cycle: valid follows start, and the outputs hold without a start. The bench checks the arithmetic against the true signed result. It does this over all operand and operation combinations, which no per-cycle rule can show. It also covers the negative-zero case on the add path and the reset values.

// File: rtl/sm_pkg.sv
package sm_pkg;

  typedef enum logic {
    PATH_MAG_ADD = 1'b0,
    PATH_MAG_SUB = 1'b1
  } sm_path_e;

  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  function automatic logic fa_cout(input logic x, input logic y, input logic ci);
    return (x & y) | (x & ci) | (y & ci);
  endfunction

  // Sign comparison picks the magnitude operation.
  function automatic sm_path_e pick_path(input logic sa, input logic sb, input logic sub);
    return (sa == (sb ^ sub)) ? PATH_MAG_ADD : PATH_MAG_SUB;
  endfunction

endpackage

// File: rtl/sm_operand_xor.sv
module sm_operand_xor #(
  parameter int MAG_W = 4
) (
  input  logic             mode,
  input  logic [MAG_W-1:0] mag_in,
  output logic [MAG_W-1:0] mag_out
);
  for (genvar i = 0; i < MAG_W; i++) begin : g_inv
    assign mag_out[i] = mag_in[i] ^ mode;
  end
endmodule

// File: rtl/sm_ripple_adder.sv
module sm_ripple_adder #(
  parameter int MAG_W = 4
) (
  input  logic [MAG_W-1:0] x,
  input  logic [MAG_W-1:0] y,
  input  logic             cin,
  output logic [MAG_W-1:0] sum,
  output logic             cout
);
  import sm_pkg::*;

  logic [MAG_W:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < MAG_W; i++) begin : g_fa
    assign sum[i]     = fa_sum(x[i], y[i], chain[i]);
    assign chain[i+1] = fa_cout(x[i], y[i], chain[i]);
  end

  assign cout = chain[MAG_W];
endmodule

// File: rtl/sm_result_fix.sv
module sm_result_fix #(
  parameter int MAG_W = 4
) (
  input  sm_pkg::sm_path_e path,
  input  logic             sign_a,
  input  logic [MAG_W-1:0] raw_sum,
  input  logic             carry,
  output logic             fix_sign,
  output logic [MAG_W-1:0] fix_mag,
  output logic             fix_ovf
);
  import sm_pkg::*;

  localparam logic [MAG_W-1:0] ONE = {{(MAG_W-1){1'b0}}, 1'b1};

  logic [MAG_W-1:0] neg_sum;
  assign neg_sum = ~raw_sum + ONE;

  always_comb begin
    fix_sign = sign_a;
    fix_mag  = raw_sum;
    fix_ovf  = 1'b0;
    if (path == PATH_MAG_ADD) begin
      fix_ovf = carry;
    end else if (carry) begin
      if (raw_sum == '0) fix_sign = 1'b0;
    end else begin
      fix_mag  = neg_sum;
      fix_sign = ~sign_a;
    end
  end
endmodule

// File: rtl/smag_addsub.sv
module smag_addsub #(
  parameter int MAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_sub,
  input  logic [MAG_W:0]   opa,
  input  logic [MAG_W:0]   opb,
  output logic             res_valid,
  output logic             res_sign,
  output logic [MAG_W-1:0] res_mag,
  output logic             res_ovf,
  output logic             res_carry
);
  import sm_pkg::*;

  logic             sign_a, sign_b;
  logic [MAG_W-1:0] mag_a, mag_b, mag_b_x, raw_sum;
  logic             carry, mode;
  sm_path_e         path;
  logic             fix_sign, fix_ovf;
  logic [MAG_W-1:0] fix_mag;

  assign sign_a = opa[MAG_W];
  assign sign_b = opb[MAG_W];
  assign mag_a  = opa[MAG_W-1:0];
  assign mag_b  = opb[MAG_W-1:0];
  assign path   = pick_path(sign_a, sign_b, op_sub);
  assign mode   = (path == PATH_MAG_SUB);

  sm_operand_xor #(.MAG_W(MAG_W)) u_xor (
    .mode(mode), .mag_in(mag_b), .mag_out(mag_b_x)
  );

  sm_ripple_adder #(.MAG_W(MAG_W)) u_add (
    .x(mag_a), .y(mag_b_x), .cin(mode), .sum(raw_sum), .cout(carry)
  );

  sm_result_fix #(.MAG_W(MAG_W)) u_fix (
    .path(path), .sign_a(sign_a), .raw_sum(raw_sum), .carry(carry),
    .fix_sign(fix_sign), .fix_mag(fix_mag), .fix_ovf(fix_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_sign  <= 1'b0;
      res_mag   <= '0;
      res_ovf   <= 1'b0;
      res_carry <= 1'b0;
    end else begin
      res_valid <= start;
      if (start) begin
        res_sign  <= fix_sign;
        res_mag   <= fix_mag;
        res_ovf   <= fix_ovf;
        res_carry <= carry;
      end
    end
  end
endmodule

// File: rtl/smag_addsub_chk.sv
module smag_addsub_chk #(
  parameter int MAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             mode,
  input logic             carry,
  input logic             sign_a,
  input logic             fix_sign,
  input logic [MAG_W-1:0] fix_mag,
  input logic             fix_ovf,
  input logic             res_valid,
  input logic             res_sign,
  input logic [MAG_W-1:0] res_mag,
  input logic             res_ovf,
  input logic             res_carry
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) mode |-> !fix_ovf); // R4
  AST_OVF_IS_CARRY: assert property (@(posedge clk) disable iff (!rst_n) !mode |-> (fix_ovf == carry)); // R3
  AST_ZERO_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n) (mode && carry && fix_mag == '0) |-> !fix_sign); // R5
  AST_NEG_FLIPS_SIGN: assert property (@(posedge clk) disable iff (!rst_n) (mode && !carry) |-> (fix_sign != sign_a)); // R6
  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> res_valid); // R7
  AST_VALID_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !res_valid); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n) !start |=> ($stable(res_sign) && $stable(res_mag) && $stable(res_ovf) && $stable(res_carry))); // R8
endmodule

bind smag_addsub smag_addsub_chk #(.MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .carry(carry),
  .sign_a(sign_a), .fix_sign(fix_sign), .fix_mag(fix_mag), .fix_ovf(fix_ovf),
  .res_valid(res_valid), .res_sign(res_sign), .res_mag(res_mag),
  .res_ovf(res_ovf), .res_carry(res_carry)
);

// File: tb/tb_smag_addsub.sv
module tb_smag_addsub;
  localparam int MAG_W = 4;
  localparam int LIM   = 1 << MAG_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             op_sub = 1'b0;
  logic [MAG_W:0]   opa = '0, opb = '0;
  logic             res_valid, res_sign, res_ovf, res_carry;
  logic [MAG_W-1:0] res_mag;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  smag_addsub #(.MAG_W(MAG_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
    .opa(opa), .opb(opb), .res_valid(res_valid), .res_sign(res_sign),
    .res_mag(res_mag), .res_ovf(res_ovf), .res_carry(res_carry)
  );

  task automatic apply(input int sa, input int ma, input int sb, input int mb, input int sub);
    int  va, vb, exact, e_sign, e_mag, e_ovf, e_cy, d, got_v;
    bit  add_path;
    string tag;
    logic             h_sign, h_ovf, h_cy;
    logic [MAG_W-1:0] h_mag;
    // Expected from signed arithmetic, R1 encoding
    va = sa ? -ma : ma;
    vb = sb ? -mb : mb;
    exact = sub ? (va - vb) : (va + vb);
    add_path = (sa == (sb ^ sub));              // R2
    if (add_path) begin                          // R3
      tag = "R3";
      e_sign = sa; e_mag = (ma + mb) % LIM;
      e_cy = (ma + mb) >= LIM; e_ovf = e_cy;
    end else begin                               // R4
      d = ma - mb; e_ovf = 0;
      if (d >= 0) begin tag = "R5"; e_cy = 1; e_mag = d; e_sign = (d == 0) ? 0 : sa; end
      else        begin tag = "R6"; e_cy = 0; e_mag = -d; e_sign = 1 - sa; end
    end
    @(negedge clk);
    opa = {sa[0], ma[MAG_W-1:0]}; opb = {sb[0], mb[MAG_W-1:0]}; op_sub = sub[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n_vec++;
    got_v = res_sign ? -int'(res_mag) : int'(res_mag);
    if (res_valid !== 1'b1 || res_sign !== e_sign[0] || res_mag !== e_mag[MAG_W-1:0] ||
        res_ovf !== e_ovf[0] || res_carry !== e_cy[0] ||
        (e_ovf == 0 && got_v != exact)) begin
      n_bad++;
      $display("FAIL %s/R7 a=%0d%0d b=%0d%0d sub=%0d: got v=%b s=%b m=%0d o=%b c=%b exp v=1 s=%0d m=%0d o=%0d c=%0d",
               tag, sa, ma, sb, mb, sub, res_valid, res_sign, res_mag, res_ovf, res_carry,
               e_sign, e_mag, e_ovf, e_cy);
    end
    // R8: new inputs without start must not disturb the held result
    h_sign = res_sign; h_mag = res_mag; h_ovf = res_ovf; h_cy = res_carry;
    opa = ~opa; opb = opb + 5'd3; op_sub = ~op_sub;
    @(negedge clk);
    n_vec++;
    if (res_valid !== 1'b0 || res_sign !== h_sign || res_mag !== h_mag ||
        res_ovf !== h_ovf || res_carry !== h_cy) begin
      n_bad++;
      $display("FAIL R8 hold: got v=%b s=%b m=%0d o=%b c=%b exp v=0 s=%b m=%0d o=%b c=%b",
               res_valid, res_sign, res_mag, res_ovf, res_carry, h_sign, h_mag, h_ovf, h_cy);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    if (res_valid !== 1'b0 || res_sign !== 1'b0 || res_mag !== '0 ||
        res_ovf !== 1'b0 || res_carry !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 reset: got v=%b s=%b m=%0d o=%b c=%b exp all 0",
               res_valid, res_sign, res_mag, res_ovf, res_carry);
    end
    rst_n = 1'b1;
    for (int sub = 0; sub < 2; sub++)
      for (int sa = 0; sa < 2; sa++)
        for (int sb = 0; sb < 2; sb++)
          for (int ma = 0; ma < LIM; ma++)
            for (int mb = 0; mb < LIM; mb++)
              apply(sa, ma, sb, mb, sub);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule